// File: doc/BRIEF.md
# Multiway-Branch Control Sequencer

This block is a control sequencer driven from a writable control store. On every clock edge it fetches one 32-bit codeword and places it in a codeword register. The register does two jobs. Its control fields leave the block as outputs. Its address fields pick the word fetched on the next edge.

The next address is formed in one of two ways. A codeword can name a fixed successor state. It can also name a 16-aligned block, and then one nibble of condition inputs is substituted into the low four address bits, which gives a one-of-16 branch in a single cycle. The condition inputs are registered before they reach this merge. The most significant address bit is the inverse of a "foreign write starting" input, so the normal program lives in the upper half of the store and every location has a companion word in the lower half.

A load port writes codewords at any time, including during reset. Every fetched word is checked against four parity bits. After reset, execution starts from address 0.

Top module: `mwb_sequencer`

## Requirements
- R1: While reset is asserted, the codeword register holds an idle word: `cyc_end_n_o`=1, `req_noted_n_o`=1, `cache_mode_o`=0, `par_err_o`=0, and `fetch_addr_o`=0. The first edge after reset releases loads the word stored at address 0.
- R2: On each edge, a fetched word with good parity is loaded into the codeword register and appears whole on `cw_o`. The outputs are fields of that word. `cache_mode_o` is bits 15:14, with 0 meaning none, 1 read, 2 write on bus transfer, and 3 write on hit. `cyc_end_n_o` is bit 20 and `req_noted_n_o` is bit 27; both are active-low.
- R3: When the condition select in bits 13:11 is 0, the low 11 fetch-address bits equal codeword bits 10:0, and the condition inputs have no effect.
- R4: When the select holds a nonzero value g, the low 11 fetch-address bits are codeword bits 10:4 followed by condition group g. Group g is `cond_i[4g-1:4g-4]` for g from 1 to 7. Group 1 carries the write-cycle and request tests, group 2 the cache tests, and group 7 the bus acknowledge and status lines.
- R5: A change on `cond_i` reaches `fetch_addr_o` only after the next clock edge.
- R6: Fetch-address bit 11 equals the inverse of `fws_i` within the same cycle.
- R7: When `ld_we_i` is high at an edge, `ld_data_i` is written at `ld_addr_i`. A fetch from that same address on that same edge returns the word that was there before.
- R8: Parity bits 31:28 are even parity: bit 28+i is the XOR of every data bit j below 28 with j mod 4 = i. When a fetched word fails this check, the codeword register keeps its old value and `par_err_o` is set.
- R9: `par_err_o` stays set until reset, even after later fetches pass the check and advance the register again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we_i | input | 1 | Load port write enable |
| ld_addr_i | input | 12 | Load port address |
| ld_data_i | input | 32 | Load port codeword, parity included |
| cond_i | input | 28 | Seven 4-bit condition groups |
| fws_i | input | 1 | Foreign write starting; selects the lower, mirror half of the store |
| cw_o | output | 32 | Current codeword |
| fetch_addr_o | output | 12 | Address fetched on the next edge |
| cache_mode_o | output | 2 | Cache mode field |
| cyc_end_n_o | output | 1 | Memory cycle ending, active-low |
| req_noted_n_o | output | 1 | Request noted, active-low |
| par_err_o | output | 1 | Sticky parity error |

## Verification
Two functions can land on the same edge: a load-port write and a fetch from the same address. The bench triggers this by rewriting the dispatch word while a block word is current, because that block word names the dispatch word as its successor. The fetch on that edge must still return the old dispatch word, and the next pass around the loop must see the new one. A second overlap is a parity failure on the same edge as a condition branch. Here the register must hold the dispatch word, refetch the bad word, and move on only after the load port repairs it, while the error flag stays set throughout.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int CW_W      = 32;
  localparam int ST_W      = 11;
  localparam int AD_W      = ST_W + 1;
  localparam int SEL_W     = 3;
  localparam int NIB_W     = 4;
  localparam int PAR_W     = 4;
  localparam int NGRP      = (1 << SEL_W) - 1;
  localparam int COND_W    = NGRP * NIB_W;
  localparam int SEL_LSB   = ST_W;
  localparam int MODE_LSB  = 14;
  localparam int END_BIT   = 20;
  localparam int NOTED_BIT = 27;
  localparam int PAR_LSB   = CW_W - PAR_W;

  typedef logic [CW_W-1:0] cw_t;
  typedef enum logic [1:0] {CM_NONE, CM_READ, CM_WR_XFER, CM_WR_HIT} cmode_e;

  function automatic logic [PAR_W-1:0] par_calc(cw_t w);
    logic [PAR_W-1:0] p;
    p = '0;
    for (int j = 0; j < PAR_LSB; j++) p[j % PAR_W] ^= w[j];
    return p;
  endfunction

  function automatic logic par_good(cw_t w);
    return par_calc(w) == w[PAR_LSB +: PAR_W];
  endfunction

  function automatic cw_t idle_word();
    cw_t w;
    w = '0;
    w[END_BIT]   = 1'b1;
    w[NOTED_BIT] = 1'b1;
    return w;
  endfunction

  function automatic logic [ST_W-1:0] branch_low(logic [ST_W-1:0] st,
                                                 logic [SEL_W-1:0] sel,
                                                 logic [NIB_W-1:0] nib);
    if (sel == '0) return st;
    return {st[ST_W-1:NIB_W], nib};
  endfunction
endpackage

// File: rtl/seq_store.sv
module seq_store #(
  parameter int W  = 32,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // asynchronous read; the codeword register samples it, so a same-edge write is seen next time
  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/seq_cond_sync.sv
module seq_cond_sync #(
  parameter int CW = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cond_i,
  output logic [CW-1:0] cond_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= '0;
    else        cond_q <= cond_i;
  end
endmodule

// File: rtl/seq_addr_gen.sv
module seq_addr_gen
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ST_W-1:0]   state_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [COND_W-1:0] cond_q_i,
  input  logic              fws_i,
  input  logic              start_i,
  output logic [AD_W-1:0]   addr_o
);
  logic [NIB_W-1:0] nib [NGRP+1];
  logic [ST_W-1:0]  low;

  assign nib[0] = '0;
  for (genvar g = 1; g <= NGRP; g++) begin : g_grp
    assign nib[g] = cond_q_i[(g-1)*NIB_W +: NIB_W];
  end

  assign low    = branch_low(state_i, sel_i, nib[sel_i]);
  assign addr_o = start_i ? '0 : {~fws_i, low};

  AST_SEL0_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && sel_i == '0) |-> addr_o[ST_W-1:0] == state_i); // R3
  AST_BLOCK_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && sel_i != '0) |-> addr_o[ST_W-1:NIB_W] == state_i[ST_W-1:NIB_W]); // R4
  AST_MSB_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |-> addr_o[AD_W-1] != fws_i); // R6
endmodule

// File: rtl/seq_cw_reg.sv
module seq_cw_reg
  import seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cw_t  rdata_i,
  output cw_t  cw_q,
  output logic start_q,
  output logic err_q,
  output logic fetch_ok
);
  assign fetch_ok = par_good(rdata_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_q    <= idle_word();
      start_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (fetch_ok) cw_q  <= rdata_i;
      else          err_q <= 1'b1;
    end
  end

  AST_LOAD_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ok |=> cw_q == $past(rdata_i)); // R2
  AST_HOLD_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_ok |=> ($stable(cw_q) && err_q)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R9
endmodule

// File: rtl/mwb_sequencer.sv
module mwb_sequencer
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we_i,
  input  logic [AD_W-1:0]   ld_addr_i,
  input  logic [CW_W-1:0]   ld_data_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic              fws_i,
  output logic [CW_W-1:0]   cw_o,
  output logic [AD_W-1:0]   fetch_addr_o,
  output logic [1:0]        cache_mode_o,
  output logic              cyc_end_n_o,
  output logic              req_noted_n_o,
  output logic              par_err_o
);
  cw_t               rdata;
  cw_t               cw_q;
  logic              start_q;
  logic              err_q;
  logic              fetch_ok;
  logic [COND_W-1:0] cond_q;
  logic [AD_W-1:0]   addr;
  cmode_e            mode;

  seq_store #(.W(CW_W), .AW(AD_W)) i_store (
    .clk(clk), .we_i(ld_we_i), .waddr_i(ld_addr_i), .wdata_i(ld_data_i),
    .raddr_i(addr), .rdata_o(rdata));

  seq_cond_sync #(.CW(COND_W)) i_sync (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .cond_q(cond_q));

  seq_addr_gen i_agen (
    .clk(clk), .rst_n(rst_n),
    .state_i(cw_q[ST_W-1:0]), .sel_i(cw_q[SEL_LSB +: SEL_W]),
    .cond_q_i(cond_q), .fws_i(fws_i), .start_i(start_q), .addr_o(addr));

  seq_cw_reg i_cwr (
    .clk(clk), .rst_n(rst_n), .rdata_i(rdata), .cw_q(cw_q),
    .start_q(start_q), .err_q(err_q), .fetch_ok(fetch_ok));

  assign mode          = cmode_e'(cw_q[MODE_LSB +: 2]);
  assign cw_o          = cw_q;
  assign fetch_addr_o  = addr;
  assign cache_mode_o  = mode;
  assign cyc_end_n_o   = cw_q[END_BIT];
  assign req_noted_n_o = cw_q[NOTED_BIT];
  assign par_err_o     = err_q;

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> addr == '0); // R1
endmodule

// File: tb/test_mwb_sequencer.sv
module test_mwb_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_we;
  logic [11:0] ld_addr;
  logic [31:0] ld_data;
  logic [27:0] cond;
  logic        fws;
  logic [31:0] cw_o;
  logic [11:0] fetch_addr_o;
  logic [1:0]  cache_mode_o;
  logic        cyc_end_n_o, req_noted_n_o, par_err_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] shadow [4096];
  logic [31:0] w0, d1, d2, d3;

  always #2 clk = ~clk;

  mwb_sequencer i_mwb_sequencer (
    .clk(clk), .rst_n(rst_n), .ld_we_i(ld_we), .ld_addr_i(ld_addr),
    .ld_data_i(ld_data), .cond_i(cond), .fws_i(fws), .cw_o(cw_o),
    .fetch_addr_o(fetch_addr_o), .cache_mode_o(cache_mode_o),
    .cyc_end_n_o(cyc_end_n_o), .req_noted_n_o(req_noted_n_o),
    .par_err_o(par_err_o));

  function automatic logic [31:0] with_par(logic [31:0] w);
    logic [31:0] r;
    r = w;
    for (int i = 0; i < 4; i++) begin
      logic p;
      p = 1'b0;
      for (int k = 0; k < 7; k++) p = p ^ w[4*k+i];
      r[28+i] = p;
    end
    return r;
  endfunction

  function automatic logic [31:0] mk(int st, int sel, int mode, int tag, int en, int nn);
    logic [31:0] w;
    w = 32'(st) | (32'(sel) << 11) | (32'(mode) << 14) | (32'(en) << 20)
      | (32'(tag) << 21) | (32'(nn) << 27);
    return with_par(w);
  endfunction

  function automatic logic [31:0] blk(int base, int i);
    return mk(16, 0, (base >> 5) & 3, i, i & 1, (base >> 11) & 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ld(int a, logic [31:0] d);
    ld_we = 1'b1; ld_addr = 12'(a); ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
    shadow[a] = d;
  endtask

  task automatic t_load_program();
    w0 = mk(16, 0, 0, 0, 1, 1);
    d1 = mk(32, 1, 1, 15, 1, 1);
    d2 = mk(64, 2, 2, 14, 0, 1);
    d3 = mk(96, 7, 3, 13, 1, 0);
    ld(0, w0);
    ld(12'h810, d1);
    ld(12'h010, mk(16, 0, 0, 12, 0, 0));
    for (int i = 0; i < 16; i++) begin
      ld(12'h820 + i, blk(12'h820, i));
      ld(12'h840 + i, blk(12'h840, i));
      ld(12'h860 + i, blk(12'h860, i));
      ld(12'h020 + i, blk(12'h020, i));
    end
  endtask

  task automatic t_reset_start();
    chk("R1 reset cyc_end_n", 32'(cyc_end_n_o), 1);
    chk("R1 reset req_noted_n", 32'(req_noted_n_o), 1);
    chk("R1 reset cache_mode", 32'(cache_mode_o), 0);
    chk("R1 reset par_err", 32'(par_err_o), 0);
    chk("R1 reset fetch addr", 32'(fetch_addr_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first word from address 0", cw_o, w0);
    chk("R3 fixed successor", 32'(fetch_addr_o), 32'h810);
  endtask

  task automatic t_group1_branch();
    @(negedge clk);
    chk("R2 dispatch word", cw_o, d1);
    chk("R2 cache mode field", 32'(cache_mode_o), 1);
    chk("R4 group1 branch addr", 32'(fetch_addr_o), 32'h825);
    cond[3:0] = 4'hA;
    #0.5;
    chk("R5 cond not yet visible", 32'(fetch_addr_o), 32'h825);
    @(negedge clk);
    chk("R4 group1 target word", cw_o, blk(12'h820, 5));
    chk("R2 active-low end bit", 32'(cyc_end_n_o), 1);
    chk("R2 active-low noted bit", 32'(req_noted_n_o), 1);
    chk("R3 sel0 ignores conditions", 32'(fetch_addr_o), 32'h810);
    @(negedge clk);
    chk("R5 cond visible after edge", 32'(fetch_addr_o), 32'h82A);
  endtask

  task automatic t_mirror();
    fws = 1'b1;
    #0.5;
    chk("R6 mirror half address", 32'(fetch_addr_o), 32'h02A);
    @(negedge clk);
    chk("R6 mirror word fetched", cw_o, blk(12'h020, 10));
    chk("R2 mirror noted low", 32'(req_noted_n_o), 0);
    fws = 1'b0;
    #0.5;
    chk("R6 normal half again", 32'(fetch_addr_o), 32'h810);
  endtask

  task automatic t_collision();
    // current word is a block word whose successor is 0x810
    ld(12'h810, d2);
    chk("R7 same-edge fetch gets old word", cw_o, d1);
    @(negedge clk);
    @(negedge clk);
    chk("R7 new word seen next pass", cw_o, d2);
    chk("R4 group2 branch addr", 32'(fetch_addr_o), 32'h843);
    ld(12'h810, d3);
    chk("R4 group2 target word", cw_o, blk(12'h840, 3));
    chk("R2 cache mode write-xfer", 32'(cache_mode_o), 2);
    @(negedge clk);
    chk("R4 group7 dispatch", cw_o, d3);
    chk("R4 group7 branch addr", 32'(fetch_addr_o), 32'h86C);
  endtask

  task automatic t_parity();
    logic [31:0] bad;
    cond[3:0] = 4'hB;
    ld(12'h810, d1);
    chk("R4 group7 target word", cw_o, blk(12'h860, 12));
    bad = blk(12'h820, 11) ^ 32'h1000_0000;
    ld(12'h82B, bad);
    chk("R8 dispatch before bad fetch", cw_o, d1);
    chk("R8 no error yet", 32'(par_err_o), 0);
    @(negedge clk);
    chk("R8 error raised", 32'(par_err_o), 1);
    chk("R8 register held", cw_o, d1);
    ld(12'h82B, blk(12'h820, 11));
    chk("R8 still held while bad", cw_o, d1);
    @(negedge clk);
    chk("R9 good fetch advances", cw_o, blk(12'h820, 11));
    chk("R9 error stays set", 32'(par_err_o), 1);
    rst_n = 1'b0;
    #0.5;
    chk("R9 reset clears error", 32'(par_err_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_we = 1'b0; ld_addr = '0; ld_data = '0;
    cond = '0; fws = 1'b0;
    cond[3:0] = 4'h5; cond[7:4] = 4'h3; cond[27:24] = 4'hC;
    repeat (2) @(negedge clk);
    t_load_program();
    t_reset_start();
    t_group1_branch();
    t_mirror();
    t_collision();
    t_parity();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule